// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a clocked request interface and an external asynchronous static RAM of 8192 bytes. A client offers one request at a time through a valid/ready handshake. Each request carries a write flag, a 13-bit word address and a byte of write data. The controller then sequences the RAM's chip selects (one active low, one active high), its write strobe, its output enable and the enable of its own data-bus driver. When the whole access window has elapsed it pulses `rsp_done` for one clock. For reads, the byte it fetched is returned at the same time.

Every timing interval is a parameter given in nanoseconds together with the clock period. Each interval is turned into a whole number of clock cycles by rounding up, with a floor of one cycle. A read holds the selects and the output enable active for the longest of three intervals: cycle time, address access and output-enable access. The returned byte is latched on the last clock of that window. A write has three phases: an address-setup phase, a write pulse and a recovery phase. The output enable stays high throughout a write. The controller's own data driver switches on only one clock after the write strobe has fallen, so the bus is never driven from both sides.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `sram_cs1_n` is 1, `sram_cs2` is 0, `sram_we_n` is 1, `sram_oe_n` is 1, `sram_dq_oe` is 0 and `rsp_done` is 0.
- R2: A read (`req_write`=0) holds `sram_cs1_n`=0, `sram_cs2`=1 and `sram_oe_n`=0 for exactly RD_LEN = max(ceil(tRC), ceil(tAA), ceil(tOE)) consecutive clocks, which is 25 at the defaults. During that window `sram_we_n` stays 1 and `sram_dq_oe` stays 0.
- R3: The byte present on `sram_dq_in` in the last clock of the read window is returned on `rsp_rdata` while `rsp_done` is 1.
- R4: A write holds the selects active for exactly AS_LEN + WP_LEN + WREC_LEN clocks, where WREC_LEN = max(ceil(tWR), ceil(tWC) - AS_LEN - WP_LEN). This is 25 at the defaults. `sram_oe_n` stays 1 throughout.
- R5: `sram_we_n` is 0 for exactly WP_LEN = max(ceil(tWP), ceil(tAW) - AS_LEN, ceil(tDW) + 1) consecutive clocks, which is 19 at the defaults. The strobe falls after AS_LEN clocks of active selects (1 at the defaults) and occurs only while the selects are active.
- R6: `sram_dq_oe` rises exactly one clock after `sram_we_n` falls. It stays high to the end of the recovery phase, giving WP_LEN - 1 + WREC_LEN clocks (23 at the defaults), and is never 1 while `sram_oe_n` is 0. While it is 1, `sram_dq_out` holds the request's write data.
- R7: `rsp_done` is 1 for exactly one clock, the clock right after the selects deassert. `req_ready` is 0 from acceptance until the clock after `rsp_done`. A `req_valid` held high during that time starts no second access.
- R8: `sram_addr` equals the accepted request's address and stays stable for every clock in which the selects are active.
- R9: Every interval is rounded up to whole clocks with a floor of one. At the default 4000 ps clock, the 0 ns setup and recovery minimums become 1 clock each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_done` after a read |
| sram_addr | output | 13 | Address to the RAM |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_out | output | 8 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Enable of the controller's data driver |
| sram_dq_in | input | 8 | Data bus as seen from the RAM |

## Verification
The bench drives directed writes and reads at the lowest and highest addresses with all-zero and all-one data. These expose address or data bits that are stuck or mis-latched. It then issues a seeded random mix of reads and writes against a behavioural RAM model. Reads of addresses written earlier tell a correct capture apart from a capture of the wrong clock or of stale data. For every access the bench counts the clocks of each strobe window, the offset of the driver enable from the write-strobe fall and the gap before the done pulse. Any off-by-one in the phase lengths is therefore visible. One directed case keeps `req_valid` asserted with a changing address during a whole access. This separates a controller that ignores requests while busy from one that restarts or alters the address mid-cycle.

// File: rtl/sram_port_pkg.sv
// Shared definitions for the asynchronous SRAM port controller.
// Holds the sequencer state type and the nanosecond-to-cycle helpers.
package sram_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_READ = 3'd1,
        ST_WSET = 3'd2,
        ST_WPUL = 3'd3,
        ST_WREC = 3'd4,
        ST_FIN  = 3'd5
    } seq_state_t;

    // Round a nanosecond minimum up to whole clocks, never below one.
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        return max2(max2(a, b), c);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one sequencer phase.
// Assumes: load is pulsed on the edge that enters a phase, with the phase
// length (>= 1); last is high during the final clock of that phase.
module sram_phase_timer #(
    parameter int MAX_LEN = 25,
    localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    // Load the phase length on entry, then count down to one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));

    // R9: a loaded length never exceeds the largest derived interval
    a_r9_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (int'(cnt) <= MAX_LEN));

endmodule

// File: rtl/sram_data_path.sv
// Address, write-data and read-data registers of the SRAM port.
// Assumes: accept is a one-clock pulse when a request is taken; capture is
// high in the final clock of a read window.
module sram_data_path #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Hold the request's address and data for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Latch the bus on the last clock of a read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (capture)
            rdata_q <= dq_in;
    end

    // R8: address register changes only when a request is taken
    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) && $past(rst_n) |-> $stable(addr_q));

endmodule

// File: rtl/sram_port_ctrl.sv
// Clocked sequencer driving an asynchronous 8K x 8 static RAM.
// Takes one request at a time over valid/ready and runs a read window or a
// setup/pulse/recovery write, all lengths derived from ns minimums and the
// clock period. Assumes the RAM's data pins are joined to sram_dq_out /
// sram_dq_in through a tristate buffer enabled by sram_dq_oe.
module sram_port_ctrl
    import sram_port_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int CLK_PS  = 4000,
    parameter int T_RC_NS = 100,
    parameter int T_AA_NS = 100,
    parameter int T_OE_NS = 50,
    parameter int T_AS_NS = 0,
    parameter int T_WP_NS = 60,
    parameter int T_AW_NS = 80,
    parameter int T_DW_NS = 40,
    parameter int T_WR_NS = 0,
    parameter int T_WC_NS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_LEN   = max3(ns_to_cyc(T_RC_NS, CLK_PS), ns_to_cyc(T_AA_NS, CLK_PS),
                                   ns_to_cyc(T_OE_NS, CLK_PS));
    localparam int AS_LEN   = ns_to_cyc(T_AS_NS, CLK_PS);
    localparam int WP_LEN   = max3(ns_to_cyc(T_WP_NS, CLK_PS), ns_to_cyc(T_AW_NS, CLK_PS) - AS_LEN,
                                   ns_to_cyc(T_DW_NS, CLK_PS) + 1);
    localparam int WREC_LEN = max2(ns_to_cyc(T_WR_NS, CLK_PS),
                                   ns_to_cyc(T_WC_NS, CLK_PS) - AS_LEN - WP_LEN);
    localparam int MAX_LEN  = max3(max2(RD_LEN, AS_LEN), WP_LEN, WREC_LEN);
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    seq_state_t       state, state_nxt;
    logic             tmr_load, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             accept, capture;
    logic             sel_q, we_q, oe_q, drv_q, done_q, ready_q;
    logic [DATA_W-1:0] wdata_q;

    assign accept  = (state == ST_IDLE) && req_valid;
    assign capture = (state == ST_READ) && tmr_last;

    // Choose the next phase from the current one and the phase timer.
    always_comb begin
        state_nxt = state;
        case (state)
            ST_IDLE: if (req_valid) state_nxt = req_write ? ST_WSET : ST_READ;
            ST_READ: if (tmr_last)  state_nxt = ST_FIN;
            ST_WSET: if (tmr_last)  state_nxt = ST_WPUL;
            ST_WPUL: if (tmr_last)  state_nxt = ST_WREC;
            ST_WREC: if (tmr_last)  state_nxt = ST_FIN;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    // Pick the length of the phase being entered.
    always_comb begin
        case (state_nxt)
            ST_READ: tmr_val = CNT_W'(RD_LEN);
            ST_WSET: tmr_val = CNT_W'(AS_LEN);
            ST_WPUL: tmr_val = CNT_W'(WP_LEN);
            ST_WREC: tmr_val = CNT_W'(WREC_LEN);
            default: tmr_val = CNT_W'(1);
        endcase
    end
    assign tmr_load = (state_nxt != state);

    // Advance the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Register every pin-facing strobe so the RAM sees glitch-free edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            we_q    <= 1'b0;
            oe_q    <= 1'b0;
            drv_q   <= 1'b0;
            done_q  <= 1'b0;
            ready_q <= 1'b1;
        end else begin
            sel_q   <= (state_nxt == ST_READ) || (state_nxt == ST_WSET) ||
                       (state_nxt == ST_WPUL) || (state_nxt == ST_WREC);
            we_q    <= (state_nxt == ST_WPUL);
            oe_q    <= (state_nxt == ST_READ);
            drv_q   <= ((state == ST_WPUL) && (state_nxt == ST_WPUL)) || (state_nxt == ST_WREC);
            done_q  <= (state_nxt == ST_FIN);
            ready_q <= (state_nxt == ST_IDLE);
        end
    end

    sram_phase_timer #(.MAX_LEN(MAX_LEN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (sram_dq_in),
        .addr_q    (sram_addr),
        .wdata_q   (wdata_q),
        .rdata_q   (rsp_rdata)
    );

    assign req_ready   = ready_q;
    assign rsp_done    = done_q;
    assign sram_cs1_n  = !sel_q;
    assign sram_cs2    = sel_q;
    assign sram_we_n   = !we_q;
    assign sram_oe_n   = !oe_q;
    assign sram_dq_oe  = drv_q;
    assign sram_dq_out = wdata_q;

    // R6: own driver never on while the RAM may drive the bus
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);
    // R6: driver turns on only after the write strobe was already low
    a_r6_drive_after_we: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> !sram_we_n && !$past(sram_we_n));
    // R5: write strobe only inside an active select window
    a_r5_we_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> !sram_cs1_n && sram_cs2);
    // R2: output enable and write strobe never active together
    a_r2_read_no_we: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> sram_we_n);
    // R7: completion is a single-clock pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R7: no acceptance while a cycle is in flight
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs1_n |-> !req_ready);
    // R8: address steady across consecutive selected clocks
    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs1_n && !$past(sram_cs1_n) && $past(rst_n) |-> $stable(sram_addr));

endmodule

// File: tb/sram_port_ctrl_test.sv
// Bench for sram_port_ctrl: behavioural RAM model, directed corners and a
// seeded random read/write mix, with phase lengths checked per access.
module sram_port_ctrl_test;

    localparam int EXP_RD   = 25;
    localparam int EXP_AS   = 1;
    localparam int EXP_WP   = 19;
    localparam int EXP_WREC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [12:0] sram_addr;
    logic        sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [7:0]  sram_dq_out;
    logic [7:0]  sram_dq_in;

    int tests = 0;
    int fails = 0;
    logic [7:0] mem [int];

    always #2 clk = ~clk;

    sram_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
        .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    function automatic logic [7:0] fill_val(input logic [12:0] a);
        return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] model_rd(input logic [12:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : fill_val(a);
    endfunction

    // RAM model: drives read data only while selected, enabled and not writing.
    always_comb begin
        if (!sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n)
            sram_dq_in = model_rd(sram_addr);
        else
            sram_dq_in = 8'hC3;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Run one access and verify the strobe timing and, for reads, the data.
    task automatic run_op(input logic wr, input logic [12:0] a, input logic [7:0] d,
                          input logic hold_valid);
        int n_sel = 0, n_oe = 0, n_we = 0, n_drv = 0, we_first = -1, drv_first = -1;
        int addr_bad = 0, oe_in_wr = 0, we_in_rd = 0, drv_bad_data = 0, gap = 0;
        int idx = 0;
        logic seen_done = 1'b0;
        logic [7:0] wval = 8'h00;
        logic [7:0] exp_rd;
        exp_rd = model_rd(a);
        @(negedge clk);
        check("R7 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        if (hold_valid) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        end else
            req_valid = 1'b0;
        while (!seen_done && idx < 200) begin
            if (rsp_done) begin
                seen_done = 1'b1;
                req_valid = 1'b0;
            end else begin
                if (!sram_cs1_n && sram_cs2) begin
                    n_sel++;
                    if (sram_addr != a) addr_bad++;
                end else gap++;
                if (req_ready) addr_bad++;
                if (!sram_oe_n) begin n_oe++; if (wr) oe_in_wr++; end
                if (!sram_we_n) begin
                    n_we++;
                    if (we_first < 0) we_first = idx;
                    if (!wr) we_in_rd++;
                end
                if (sram_dq_oe) begin
                    n_drv++;
                    if (drv_first < 0) drv_first = idx;
                    if (sram_dq_out != d) drv_bad_data++;
                    if (!sram_we_n) wval = sram_dq_out;
                end
                idx++;
                @(negedge clk);
            end
        end
        check("R7 done seen", int'(seen_done), 1);
        check("R7 done right after selects drop", gap, 0);
        check("R8 address held, no busy ready", addr_bad, 0);
        if (wr) begin
            check("R4 write select length", n_sel, EXP_AS + EXP_WP + EXP_WREC);
            check("R4 oe high during write", oe_in_wr, 0);
            check("R5 write pulse length", n_we, EXP_WP);
            check("R9 setup rounded to one clock", we_first, EXP_AS);
            check("R6 drive one clock after we fall", drv_first, we_first + 1);
            check("R6 drive length", n_drv, EXP_WP - 1 + EXP_WREC);
            check("R6 drive data", drv_bad_data, 0);
            mem[int'(a)] = wval;
        end else begin
            check("R2 read select length", n_sel, EXP_RD);
            check("R2 oe length", n_oe, EXP_RD);
            check("R2 no we or drive in read", we_in_rd + n_drv, 0);
            check("R3 read data", int'(rsp_rdata), int'(exp_rd));
        end
        @(negedge clk);
        check("R7 done single pulse", int'(rsp_done), 0);
        check("R7 ready after done", int'(req_ready), 1);
        check("R7 no second access started", int'(sram_cs1_n), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 11;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready", int'(req_ready), 1);
        check("R1 cs1_n", int'(sram_cs1_n), 1);
        check("R1 cs2", int'(sram_cs2), 0);
        check("R1 we_n", int'(sram_we_n), 1);
        check("R1 oe_n", int'(sram_oe_n), 1);
        check("R1 dq_oe", int'(sram_dq_oe), 0);
        check("R1 done", int'(rsp_done), 0);

        run_op(1'b0, 13'h0ABC, 8'h00, 1'b0);
        run_op(1'b1, 13'h0000, 8'hFF, 1'b0);
        run_op(1'b1, 13'h1FFF, 8'h00, 1'b0);
        run_op(1'b0, 13'h0000, 8'h00, 1'b0);
        run_op(1'b0, 13'h1FFF, 8'h00, 1'b0);
        run_op(1'b1, 13'h0555, 8'hA5, 1'b1);
        run_op(1'b0, 13'h0555, 8'h00, 1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [12:0] ra;
            ra = 13'($urandom_range(0, 31)) | (13'($urandom_range(0, 3)) << 11);
            run_op(1'($urandom_range(0, 1)), ra, 8'($urandom), 1'($urandom_range(0, 1)));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule